// File: doc/BRIEF.md
# BCD Up/Down Counter Digit

This block is one decimal digit of a counter that can count either way. It holds a value from zero to nine in a 4-bit register that changes on the rising clock edge. A single direction input sets up or down counting and may change at any time. The counter advances only while its active-low enable is low. An active-low load input copies a 4-bit value into the register and takes priority over counting.

Two outputs support multi-digit use. The terminal flag is high whenever the digit stands at its end value for the current direction: nine when counting up, zero when counting down. The active-low carry strobe goes low at that end value only while the digit is enabled and the clock is in its low half, so it is free of glitches from the count edge. A synchronous chain drives the enable of each higher digit with the enabled terminal flag of the digit below it. The bench builds a 00 to 99 counter this way.

Top module: `bcd_updown_digit`

## Requirements
- R1: While the synchronous active-high reset is high at a rising edge, the count becomes 0.
- R2: With load_n low at a rising edge, the count takes the value of load_val, whatever the state of en_n and dir_down.
- R3: With load_n high and en_n high at a rising edge, the count keeps its value.
- R4: With dir_down = 0, load_n high and en_n low, each edge adds one, and 9 is followed by 0.
- R5: With dir_down = 1, load_n high and en_n low, each edge subtracts one, and 0 is followed by 9.
- R6: A change of dir_down takes effect at the next edge, counting in the new direction from the value then held.
- R7: at_end is 1 exactly when (dir_down = 0 and count = 9) or (dir_down = 1 and count = 0), and follows dir_down without waiting for an edge.
- R8: carry_n is 0 only while at_end is 1, en_n is 0 and clk is 0; in the high half of the clock it is 1.
- R9: From a loaded value above 9, an enabled up step gives 0 and an enabled down step gives the value minus one.
- R10: Two digits, the higher one enabled by the enabled terminal flag of the lower one, count as one two-digit decimal counter that wraps between 99 and 00 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low |
| en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_val | input | 4 | Value copied in by a load |
| count | output | 4 | Registered digit value |
| at_end | output | 1 | Terminal flag for the current direction |
| carry_n | output | 1 | Carry strobe, active low, during the low clock half |

## Verification
A wrong stored value shows on count at the very next rising edge. It also moves the terminal flag, and therefore the carry strobe, in the low half of that same cycle. A wrong step or wrap rule shows one edge after the digit reaches the value in question. In the cascade, the higher digit is then wrong one edge later. A carry strobe that is not gated by the clock phase or by the enable shows up in the half cycle after the terminal value is reached.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/bcd_step.sv
module bcd_step #(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic [W-1:0]           cur,
  input  bcd_digit_pkg::dir_e    dir,
  output logic [W-1:0]           nxt
);
  localparam logic [W-1:0] TOP = W'(LAST);

  // Up: anything at or above the top value recovers to zero.
  // Down: zero wraps to the top value, anything else steps by one.
  always_comb begin
    if (dir == bcd_digit_pkg::DIR_UP)
      nxt = (cur >= TOP) ? '0 : cur + 1'b1;
    else
      nxt = (cur == '0) ? TOP : cur - 1'b1;
  end
endmodule

// File: rtl/bcd_term_detect.sv
module bcd_term_detect #(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic                clk,
  input  logic [W-1:0]        cnt,
  input  bcd_digit_pkg::dir_e dir,
  input  logic                en_n,
  output logic                at_end,
  output logic                carry_n
);
  localparam logic [W-1:0] TOP = W'(LAST);

  always_comb begin
    if (dir == bcd_digit_pkg::DIR_DOWN) at_end = (cnt == '0);
    else                                at_end = (cnt == TOP);
  end

  // Strobe only in the low clock half, after the count has settled.
  assign carry_n = ~(at_end & ~en_n & ~clk);
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit #(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic         en_n,
  input  logic         dir_down,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         at_end,
  output logic         carry_n
);
  import bcd_digit_pkg::*;

  localparam logic [W-1:0] TOP = W'(LAST);

  dir_e         dir;
  logic [W-1:0] step_val;

  assign dir = dir_e'(dir_down);

  bcd_step #(.W(W), .LAST(LAST)) u_step (
    .cur (count),
    .dir (dir),
    .nxt (step_val)
  );

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (!load_n) count <= load_val;
    else if (!en_n)   count <= step_val;
  end

  bcd_term_detect #(.W(W), .LAST(LAST)) u_term (
    .clk     (clk),
    .cnt     (count),
    .dir     (dir),
    .en_n    (en_n),
    .at_end  (at_end),
    .carry_n (carry_n)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> count == '0);  // R1

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> count == $past(load_val));  // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (load_n && en_n) |=> $stable(count));  // R3

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_n && !dir_down && count == TOP) |=> count == '0);  // R4

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_n && dir_down && count == '0) |=> count == TOP);  // R5

  AST_OVER_UP: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_n && !dir_down && count > TOP) |=> count == '0);  // R9

  always_comb begin
    if (clk) AST_CARRY_IDLE_HIGH: assert (carry_n);  // R8
  end
endmodule

// File: tb/test_bcd_updown_digit.sv
`timescale 1ns/1ps
module test_bcd_updown_digit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       load_n = 1'b1, en_n = 1'b1, dir_down = 1'b0;
  logic [3:0] load_val = 4'd0;
  logic [3:0] count;
  logic       at_end, carry_n;

  bcd_updown_digit i_bcd_updown_digit (
    .clk(clk), .rst(rst), .load_n(load_n), .en_n(en_n), .dir_down(dir_down),
    .load_val(load_val), .count(count), .at_end(at_end), .carry_n(carry_n)
  );

  // Two-digit synchronous cascade
  logic       c_en_n = 1'b1, c_dir = 1'b0;
  logic [3:0] ones_q, tens_q;
  logic       ones_end, tens_end, ones_cy, tens_cy, tens_en_n;
  assign tens_en_n = ~(ones_end & ~c_en_n);

  bcd_updown_digit u_ones (
    .clk(clk), .rst(rst), .load_n(1'b1), .en_n(c_en_n), .dir_down(c_dir),
    .load_val(4'd0), .count(ones_q), .at_end(ones_end), .carry_n(ones_cy)
  );
  bcd_updown_digit u_tens (
    .clk(clk), .rst(rst), .load_n(1'b1), .en_n(tens_en_n), .dir_down(c_dir),
    .load_val(4'd0), .count(tens_q), .at_end(tens_end), .carry_n(tens_cy)
  );

  int n_vec = 0, n_bad = 0;
  int m_cnt = 0, m_two = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_end(input int v, input logic dn);
    return dn ? int'(v == 0) : int'(v == 9);
  endfunction

  // One clock: drive at the falling edge, check the low half, step the
  // model at the rising edge, check the high half.
  task automatic step(input logic ld, input logic en, input logic dn,
                      input int d, input string tag);
    int e;
    @(negedge clk);
    load_n = ld; en_n = en; dir_down = dn; load_val = 4'(d);
    #2;
    e = exp_end(m_cnt, dn);
    chk("R7", {tag, " at_end"}, int'(at_end), e);
    chk("R8", {tag, " carry_n low half"}, int'(carry_n), (e == 1 && !en) ? 0 : 1);
    chk("R10", {tag, " cascade end"}, int'(ones_end), exp_end(m_two % 10, c_dir));
    @(posedge clk);
    if (rst) m_cnt = 0;
    else if (!ld) m_cnt = d;
    else if (!en) begin
      if (!dn) m_cnt = (m_cnt >= 9) ? 0 : m_cnt + 1;
      else     m_cnt = (m_cnt == 0) ? 9 : m_cnt - 1;
    end
    if (rst) m_two = 0;
    else if (!c_en_n) m_two = c_dir ? (m_two + 99) % 100 : (m_two + 1) % 100;
    #2;
    chk(tag, "count", int'(count), m_cnt);
    chk("R8", {tag, " carry_n high half"}, int'(carry_n), 1);
    chk("R10", "cascade value", 10 * int'(tens_q) + int'(ones_q), m_two);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    step(1, 1, 0, 0, "R1");
    step(1, 0, 0, 0, "R1");
    rst = 1'b0;
    // R4: up through the wrap
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, "R4");
    // R3: hold, including at the terminal value (carry stays high)
    step(0, 1, 0, 9, "R2");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R3");
    step(1, 1, 1, 0, "R3");
    // R5: down through the wrap
    for (int i = 0; i < 12; i++) step(1, 0, 1, 0, "R5");
    // R2: load with enable off and on, both directions
    step(0, 1, 0, 7, "R2");
    step(0, 0, 1, 3, "R2");
    step(0, 0, 0, 0, "R2");
    // R6: reversals, including right at the wrap points
    step(1, 0, 1, 0, "R6");
    step(1, 0, 0, 0, "R6");
    step(1, 0, 0, 0, "R6");
    step(1, 0, 1, 0, "R6");
    step(1, 0, 1, 0, "R6");
    step(0, 1, 0, 9, "R2");
    step(1, 0, 1, 0, "R6");
    step(1, 0, 0, 0, "R6");
    // R9: out-of-range recovery
    step(0, 1, 0, 14, "R2");
    step(1, 0, 0, 0, "R9");
    step(0, 1, 0, 13, "R2");
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, "R9");
    step(0, 0, 1, 15, "R2");
    step(1, 0, 1, 0, "R9");
    step(0, 0, 0, 10, "R2");
    step(1, 0, 0, 0, "R9");
    // R10: cascade up past 99, then down past 00, then held
    c_en_n = 1'b0; c_dir = 1'b0;
    for (int i = 0; i < 105; i++) step(1, 1, 0, 0, "R10");
    c_dir = 1'b1;
    for (int i = 0; i < 30; i++) step(1, 1, 0, 0, "R10");
    c_en_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R10");
    // R1: reset from a nonzero value
    rst = 1'b1;
    step(1, 0, 0, 0, "R1");
    rst = 1'b0;
    step(1, 1, 0, 0, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule